// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Cycle Controller

This block sits between a synchronous host and an asynchronous 256K x 16 pseudo-static RAM. The host presents a request strobe together with a write flag, an 18-bit word address, 16-bit write data and a two-bit byte-lane mask. The controller turns that request into a read or write cycle on the memory's active-low strobes. Every phase of the cycle lasts a whole number of system clocks, and each phase length is a parameter taken from the memory's nanosecond limits, rounded up.

On a write, the controller raises the address and byte enables together with chip enable. Write enable stays high for a setup phase, then goes low for the write pulse, then returns high for one recovery clock. The data bus is driven only while write enable is low. On a read, chip enable and output enable stay low for the read phase, and the data lines are sampled on its last clock. The result comes back with a one-clock valid pulse, and lanes that were not enabled read as zero. After a read, a turnaround phase with every strobe high lets the memory release the bus before the controller can drive it again.

Top module: `psram_cycle_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, chip enable, write enable, output enable and both byte enables are high, the data bus is released (`mem_doe` = 0), `ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted on a clock edge where `req` and `ready` are both 1. The address, lane mask and write data are latched at that edge, and `mem_addr`, `mem_lb_n` and `mem_ub_n` stay constant for as long as chip enable is low.
- R3: A read holds chip enable and output enable low and write enable high for exactly RD_CYC clocks. Lane mask bit 0 drives `mem_lb_n` (data bits 7:0) and bit 1 drives `mem_ub_n` (data bits 15:8), each active low.
- R4: Read data is sampled on the last clock of the read phase. `rd_valid` is high for exactly one clock, and data bits of a lane whose mask bit is 0 are returned as zero.
- R5: A write holds chip enable low throughout. Write enable is high for WSET_CYC clocks, then low for exactly WLOW_CYC clocks, then high for one recovery clock. Output enable stays high throughout.
- R6: `mem_doe` is 1 exactly while write enable is low, and `mem_dout` then carries the latched write data.
- R7: After a read, every strobe is high for TURN_CYC clocks before `ready` returns. The data bus is therefore never driven until output enable has been high for at least TURN_CYC clocks.
- R8: Chip enable is high on the clock on which a request is accepted, so it is high for at least one clock between any two cycles, back-to-back requests included.
- R9: `ready` is 0 from the clock after acceptance until the last phase ends: RD_CYC+TURN_CYC clocks for a read and WSET_CYC+WLOW_CYC+1 clocks for a write. A `req` raised while `ready` is 0 is ignored.
- R10: A write leaves unchanged the memory lane whose mask bit is 0. A write with mask 00 changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, accepted when `ready` is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller idle, able to accept a request |
| rd_data | output | 16 | Read result, masked lanes zero |
| rd_valid | output | 1 | One-clock pulse qualifying `rd_data` |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_addr | output | 18 | Memory address |
| mem_dout | output | 16 | Write data towards the memory |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data returned by the memory |

## Verification
The embedded properties watch the strobe relationships on every clock. They check that output enable and write enable are never low together, that no strobe is low while `ready` is high, that the bus is driven only under a low write enable, and that address and byte enables hold still while chip enable is low. They also check that the bus is never driven before output enable has been quiet for the turnaround time, and that the valid pulse lasts one clock. Only the bench scenarios can show the data-level results. These are read data that comes from the last clock of the read phase and not from an earlier one, lanes preserved by masked writes, zeroed lanes on masked reads, a request ignored while busy, and the exact lengths of the busy period and of the write pulse.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;

    localparam int unsigned ADDR_W = 18;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_TURN,
        PH_WSET,
        PH_WLOW,
        PH_WREC
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
    } xfer_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    // Strobe levels seen on the memory pins during each phase.
    function automatic strobe_t phase_strobes(input phase_e ph);
        strobe_t s;
        s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        case (ph)
            PH_RD:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
            PH_WSET: s.ce_n = 1'b0;
            PH_WLOW: begin s.ce_n = 1'b0; s.we_n = 1'b0; end
            PH_WREC: s.ce_n = 1'b0;
            default: s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        endcase
        return s;
    endfunction

    // Phase that follows the last clock of a given phase.
    function automatic phase_e phase_after(input phase_e ph);
        case (ph)
            PH_RD:   return PH_TURN;
            PH_WSET: return PH_WLOW;
            PH_WLOW: return PH_WREC;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/psram_xfer_latch.sv
module psram_xfer_latch
    import psram_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  xfer_t d,
    output xfer_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/psram_phase_seq.sv
module psram_phase_seq
    import psram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 8,
    parameter int unsigned WSET_CYC = 2,
    parameter int unsigned WLOW_CYC = 5,
    parameter int unsigned TURN_CYC = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   is_wr,
    output phase_e phase,
    output logic   ready,
    output logic   rd_last
);

    localparam int unsigned MAX_A = (RD_CYC > WLOW_CYC) ? RD_CYC : WLOW_CYC;
    localparam int unsigned MAX_B = (WSET_CYC > TURN_CYC) ? WSET_CYC : TURN_CYC;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW    = $clog2(MAX_C + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          at_end;

    always_comb begin
        case (phase)
            PH_RD:   limit = CW'(RD_CYC);
            PH_TURN: limit = CW'(TURN_CYC);
            PH_WSET: limit = CW'(WSET_CYC);
            PH_WLOW: limit = CW'(WLOW_CYC);
            default: limit = CW'(1);
        endcase
    end

    assign at_end  = (phase != PH_IDLE) && (cnt == limit - 1'b1);
    assign ready   = (phase == PH_IDLE);
    assign rd_last = (phase == PH_RD) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (start) begin
                phase <= is_wr ? PH_WSET : PH_RD;
            end
        end else if (at_end) begin
            phase <= phase_after(phase);
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: a new cycle only begins from the idle phase
    p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> (phase != PH_RD && phase != PH_WSET) || $stable(phase)
            || $past(at_end));

endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture
    import psram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[l*8 +: 8] <= '0;
            end else if (sample) begin
                rdata[l*8 +: 8] <= lanes[l] ? din[l*8 +: 8] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= sample;
        end
    end

    // R4: the valid pulse lasts a single clock
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

endmodule

// File: rtl/psram_cycle_ctrl.sv
module psram_cycle_ctrl
    import psram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 8,
    parameter int unsigned WSET_CYC = 2,
    parameter int unsigned WLOW_CYC = 5,
    parameter int unsigned TURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int unsigned QW = $clog2(TURN_CYC + 1) + 1;

    logic             accept;
    xfer_t            incoming;
    xfer_t            cur;
    phase_e           phase;
    logic             sample;
    strobe_t          strb;
    logic [LANES-1:0] lane_en_n;

    assign accept   = req && ready;
    assign incoming = '{wr: req_wr, addr: req_addr, wdata: req_wdata, lanes: req_be};

    psram_xfer_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .d    (incoming),
        .q    (cur)
    );

    psram_phase_seq #(
        .RD_CYC   (RD_CYC),
        .WSET_CYC (WSET_CYC),
        .WLOW_CYC (WLOW_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .is_wr   (req_wr),
        .phase   (phase),
        .ready   (ready),
        .rd_last (sample)
    );

    psram_rd_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .lanes  (cur.lanes),
        .din    (mem_din),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    always_comb begin
        strb      = phase_strobes(phase);
        lane_en_n = ~(cur.lanes & {LANES{strb.ce_n == 1'b0}});
    end

    assign mem_ce_n = strb.ce_n;
    assign mem_we_n = strb.we_n;
    assign mem_oe_n = strb.oe_n;
    assign mem_lb_n = lane_en_n[0];
    assign mem_ub_n = lane_en_n[LANES-1];
    assign mem_addr = cur.addr;
    assign mem_dout = cur.wdata;
    assign mem_doe  = (phase == PH_WLOW);

    // Clocks since output enable was last low, saturating at TURN_CYC.
    logic [QW-1:0] oe_quiet;
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_quiet <= QW'(TURN_CYC);
        end else if (!mem_oe_n) begin
            oe_quiet <= '0;
        end else if (oe_quiet < QW'(TURN_CYC)) begin
            oe_quiet <= oe_quiet + 1'b1;
        end
    end

    // R7: bus driven only after the memory has had time to release it
    p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> (oe_quiet >= QW'(TURN_CYC)));

    // R3: read and write strobes never overlap
    p_oe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R6: data bus only driven under a low write enable
    p_drive_we_r6: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

    // R9: no strobe is active while the controller reports idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_doe));

    // R2: address and lane enables held while chip enable stays low
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

    // R5: write pulse is framed by chip enable on both sides
    p_we_framed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_ce_n);

endmodule

// File: tb/psram_cycle_ctrl_bench.sv
module psram_cycle_ctrl_bench;
    import psram_ctl_pkg::*;

    localparam int RD = 8;
    localparam int WS = 2;
    localparam int WL = 5;
    localparam int TN = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    logic              req, req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [LANES-1:0]  req_be;
    logic              ready, rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_doe;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dout, mem_din;

    psram_cycle_ctrl u_psram_cycle_ctrl (
        .clk, .rst, .req, .req_wr, .req_addr, .req_wdata, .req_be,
        .ready, .rd_data, .rd_valid,
        .mem_ce_n, .mem_we_n, .mem_oe_n, .mem_ub_n, .mem_lb_n,
        .mem_addr, .mem_dout, .mem_doe, .mem_din
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [15:0] exp_q [$];
    logic [15:0] shadow [logic [17:0]];
    logic [15:0] model  [logic [17:0]];
    int          rd_age = 0;

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // Memory model: data valid only on the last read clock, other lanes junk.
    always @(posedge clk) begin
        logic [15:0] w;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
        if (!mem_ce_n && !mem_we_n) begin
            w = model.exists(mem_addr) ? model[mem_addr] : 16'h0000;
            if (!mem_lb_n) w[7:0]  = mem_dout[7:0];
            if (!mem_ub_n) w[15:8] = mem_dout[15:8];
            model[mem_addr] = w;
        end
    end

    always_comb begin
        logic [15:0] w;
        w = model.exists(mem_addr) ? model[mem_addr] : 16'h0000;
        if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= RD - 1)
            mem_din = {mem_ub_n ? 8'h5A : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
        else
            mem_din = 16'hC3C3;
    end

    // Monitor: scoreboard pop, pulse width, write pulse length, drive rules.
    bit prev_valid = 1'b0;
    bit prev_doe   = 1'b0;
    int we_run     = 0;
    int oe_hi      = 100;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R4 unexpected valid", 32'(rd_data), 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R4 read data", 32'(rd_data), 32'(e));
                end
                check(!prev_valid, "R4 valid one clock", 32'(prev_valid), 0);
            end
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                check(we_run == WL, "R5 write pulse length", 32'(we_run), 32'(WL));
                we_run = 0;
            end
            check(mem_doe == !mem_we_n, "R6 drive follows write enable",
                  32'(mem_doe), 32'(!mem_we_n));
            if (mem_doe && !prev_doe)
                check(oe_hi >= TN, "R7 turnaround before drive", 32'(oe_hi), 32'(TN));
            if (!mem_oe_n) oe_hi = 0;
            else oe_hi++;
            prev_valid = rd_valid;
            prev_doe   = mem_doe;
        end
    end

    // Driver: issues one request, pushes the expected result, measures busy time.
    task automatic xfer(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit poke);
        int n;
        logic [15:0] old;
        logic [15:0] m;
        check(ready == 1'b1, "R9 ready before request", 32'(ready), 1);
        check(mem_ce_n == 1'b1, "R8 chip enable high in accept cycle", 32'(mem_ce_n), 1);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        #1 req = 1'b0;
        @(negedge clk);
        check(mem_addr == a, "R2 address latched", 32'(mem_addr), 32'(a));
        check({mem_ub_n, mem_lb_n} == ~be, "R3 byte enables from mask",
              32'({mem_ub_n, mem_lb_n}), 32'(~be));
        m   = {{8{be[1]}}, {8{be[0]}}};
        old = shadow.exists(a) ? shadow[a] : 16'h0000;
        if (wr) shadow[a] = (old & ~m) | (d & m);
        else exp_q.push_back(old & m);
        n = 0;
        while (!ready) begin
            n++;
            if (poke && n == 2) begin
                req = 1'b1; req_wr = 1'b1; req_addr = a ^ 18'h1; req_wdata = 16'hDEAD;
                req_be = 2'b11;
            end
            if (poke && n == 5) req = 1'b0;
            @(negedge clk);
        end
        check(n == (wr ? WS + WL + 1 : RD + TN), "R9 busy length", 32'(n),
              32'(wr ? WS + WL + 1 : RD + TN));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n} == 5'h1F,
              "R1 strobes high in reset", 32'({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}),
              32'h1F);
        rst = 1'b0;
        @(negedge clk);
        check(ready && !mem_doe && !rd_valid && mem_ce_n, "R1 idle after reset",
              32'({ready, mem_doe, rd_valid, mem_ce_n}), 32'b1001);

        // R5/R3: full word write then read back
        xfer(1'b1, 18'h00123, 16'hA1B2, 2'b11, 1'b0);
        xfer(1'b0, 18'h00123, 16'h0000, 2'b11, 1'b0);
        // R10: low-lane write keeps the upper lane
        xfer(1'b1, 18'h00123, 16'hFF3C, 2'b01, 1'b0);
        xfer(1'b0, 18'h00123, 16'h0000, 2'b11, 1'b0);
        // R10: high-lane write keeps the lower lane
        xfer(1'b1, 18'h00123, 16'h7700, 2'b10, 1'b0);
        xfer(1'b0, 18'h00123, 16'h0000, 2'b11, 1'b0);
        // R4: partial-lane reads return zero in masked lanes
        xfer(1'b0, 18'h00123, 16'h0000, 2'b01, 1'b0);
        xfer(1'b0, 18'h00123, 16'h0000, 2'b10, 1'b0);
        // R10: mask 00 writes nothing; R4: mask 00 reads zero
        xfer(1'b1, 18'h00123, 16'h1111, 2'b00, 1'b0);
        xfer(1'b0, 18'h00123, 16'h0000, 2'b11, 1'b0);
        xfer(1'b0, 18'h00123, 16'h0000, 2'b00, 1'b0);
        // Address extremes
        xfer(1'b1, 18'h00000, 16'h0F0F, 2'b11, 1'b0);
        xfer(1'b1, 18'h3FFFF, 16'hF0F0, 2'b11, 1'b0);
        xfer(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0);
        xfer(1'b0, 18'h3FFFF, 16'h0000, 2'b11, 1'b0);
        // R9: request raised while busy is ignored
        xfer(1'b1, 18'h00200, 16'h4242, 2'b11, 1'b1);
        xfer(1'b0, 18'h00201, 16'h0000, 2'b11, 1'b0);
        // R7/R8: read immediately followed by a write, then a sweep
        for (int i = 0; i < 16; i++) begin
            xfer(1'b0, 18'h00123, 16'h0000, 2'b11, 1'b0);
            xfer(1'b1, 18'(18'h01000 + i * 37), 16'(16'h1357 * (i + 1)), 2'(i % 4), 1'b0);
        end
        for (int i = 0; i < 16; i++)
            xfer(1'b0, 18'(18'h01000 + i * 37), 16'h0000, 2'b11, 1'b0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 every read answered", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule